// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a clock-enable supplied at the instruction rate. Before it reaches the counter, the enable is thinned by an input prescaler of 1, 4 or 16. The counter runs from zero up to the value held in a period register. On the next counting step after that, it drops back to zero and emits a single-cycle match pulse. Other peripherals use this pulse as a time base, for example a serial shift-clock generator or a PWM period generator.

The match pulse also feeds a 4-bit postscaler with a ratio from 1:1 to 1:16. Each time the postscaler completes a cycle, it sets a sticky interrupt flag. The interrupt request output is this flag gated by an enable bit.

Software reaches the count, period, control and interrupt registers through a small synchronous register bus. Writes take effect at the clock edge. Reads are combinational. A write to the count register or to the control register restarts both scaler counters. A write to the control register leaves the count itself unchanged.

Top module: `period_timer`

## Requirements
- R1: Register addresses on `regAddr` are: 0 count, 1 period, 2 control, 3 interrupt. After reset, the count reads 0x00, the period reads 0xFF, the control reads 0x00 and the interrupt register reads 0x00.
- R2: Control layout: bit 2 is the timer enable. Bits 1:0 select the prescale ratio: 00 gives 1:1, 01 gives 1:4, 1x gives 1:16. Bits 6:3 hold a value N that selects a postscale ratio of 1:(N+1). Bit 7 always reads 0.
- R3: With the timer enabled, every prescaled step raises the count by one. A step taken while the count equals the period sets the count to 0 instead.
- R4: `matchPulse` is high for exactly the cycle in which a step is taken while the count equals the period.
- R5: After N+1 match events, the postscaler sets the interrupt flag (interrupt register bit 0).
- R6: The interrupt flag stays set until software writes 0 to interrupt bit 0. Interrupt bit 1 is the enable. `irq` is high exactly when both bits are 1.
- R7: A write to the control register restarts both scaler counters and does not change the count.
- R8: A write to the count register loads the count and restarts both scaler counters.
- R9: While the enable bit is 0, the count and the scaler counters hold their values, `tickEn` has no effect, and register writes still take effect.
- R10: The period register accepts any 8-bit value. A period of 0 makes every step a match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Instruction-rate count enable |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regAddr` (combinational) |
| matchPulse | output | 1 | One-cycle period-match pulse, taken before the postscaler |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Every prescale code is run, including both codes that select 1:16. Postscale ratios at both ends of the range are run as well. A mis-decoded select field would show up as a count or flag value that is off by a multiple of the ratio.

Scaler restart is checked by leaving the prescaler partway through a cycle and then writing the control or count register. A design that skipped the restart would step one tick early. A design that cleared the count on a control write would lose the count.

A period of zero is checked. A design that compared against the period before incrementing would fail to fire on every step.

The bench also covers flag stickiness, gating by the enable bit, and holding while disabled. A leaky design would drift or drop the flag.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_INTR   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCount;
    logic wrPeriod;
    logic wrIntr;
    logic clrScalers;
    logic step;
  } strobes_t;
endpackage

// File: rtl/period_timer_ctrl.sv
module period_timer_ctrl
  import period_timer_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [6:0]        ctrlQ,
  output strobes_t          strb
);
  localparam logic [PRE_W-1:0] LIM1  = '0;
  localparam logic [PRE_W-1:0] LIM4  = PRE_W'(3);
  localparam logic [PRE_W-1:0] LIM16 = PRE_W'(15);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             running;
  logic             clrScalers;
  logic             stepNow;

  always_comb begin
    unique casez (ctrlQ[1:0])
      2'b00:   preLimit = LIM1;
      2'b01:   preLimit = LIM4;
      default: preLimit = LIM16;
    endcase
  end

  assign running    = ctrlQ[2];
  assign clrScalers = wrEn && (regAddr == ADDR_COUNT || regAddr == ADDR_CTRL);
  assign stepNow    = tickEn && running && (preCnt == preLimit) && !clrScalers;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      preCnt <= '0;
    end else begin
      if (wrEn && regAddr == ADDR_CTRL) ctrlQ <= wrData[6:0];
      if (clrScalers)                   preCnt <= '0;
      else if (stepNow)                 preCnt <= '0;
      else if (tickEn && running)       preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.wrCount    = wrEn && regAddr == ADDR_COUNT;
    strb.wrPeriod   = wrEn && regAddr == ADDR_PERIOD;
    strb.wrIntr     = wrEn && regAddr == ADDR_INTR;
    strb.clrScalers = clrScalers;
    strb.step       = stepNow;
  end
endmodule

// File: rtl/period_timer_datapath.sv
module period_timer_datapath
  import period_timer_pkg::*;
#(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [POST_W-1:0] postSel,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] periodQ,
  output logic              flagQ,
  output logic              intEnQ,
  output logic              matchNow
);
  logic [POST_W-1:0] postCnt;
  logic              postFire;

  assign matchNow = strb.step && (countQ == periodQ);
  assign postFire = matchNow && (postCnt == postSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      periodQ <= '1;
      postCnt <= '0;
      flagQ   <= 1'b0;
      intEnQ  <= 1'b0;
    end else begin
      if (strb.wrCount)   countQ <= wrData;
      else if (matchNow)  countQ <= '0;
      else if (strb.step) countQ <= countQ + 1'b1;

      if (strb.wrPeriod) periodQ <= wrData;

      if (strb.clrScalers) postCnt <= '0;
      else if (postFire)   postCnt <= '0;
      else if (matchNow)   postCnt <= postCnt + 1'b1;

      if (postFire)         flagQ <= 1'b1;
      else if (strb.wrIntr) flagQ <= wrData[0];

      if (strb.wrIntr) intEnQ <= wrData[1];
    end
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              matchPulse,
  output logic              irq
);
  strobes_t          strb;
  logic [6:0]        ctrlQ;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] periodQ;
  logic              flagQ;
  logic              intEnQ;

  period_timer_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .ctrlQ(ctrlQ), .strb(strb)
  );

  period_timer_datapath #(.POST_W(POST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .postSel(ctrlQ[6:3]), .countQ(countQ), .periodQ(periodQ),
    .flagQ(flagQ), .intEnQ(intEnQ), .matchNow(matchPulse)
  );

  assign irq = flagQ && intEnQ;

  always_comb begin
    unique case (regAddr)
      ADDR_COUNT:  rdData = countQ;
      ADDR_PERIOD: rdData = periodQ;
      ADDR_CTRL:   rdData = {1'b0, ctrlQ};
      default:     rdData = {6'b0, intEnQ, flagQ};
    endcase
  end
endmodule

// File: rtl/period_timer_checker.sv
module period_timer_checker
  import period_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              matchPulse,
  input logic              irq,
  input logic [DATA_W-1:0] countQ,
  input logic [DATA_W-1:0] periodQ,
  input logic [6:0]        ctrlQ,
  input logic              flagQ
);
  // R3
  match_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !(wrEn && regAddr == ADDR_COUNT)) |=> (countQ == '0));

  // R4
  match_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> (countQ == periodQ));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(wrEn && regAddr == ADDR_INTR)) |=> flagQ);

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[2] && !wrEn) |=> $stable(countQ));

  // R9
  disabled_nomatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[2] |-> !matchPulse);

  // R2
  ctrl_bit7_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> !rdData[7]);

  // R7
  ctrl_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_CTRL) |=> $stable(countQ));

  // R4
  no_tick_no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> !matchPulse);
endmodule

bind period_timer period_timer_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .regAddr(regAddr),
  .rdData(rdData), .matchPulse(matchPulse), .irq(irq), .countQ(countQ),
  .periodQ(periodQ), .ctrlQ(ctrlQ), .flagQ(flagQ)
);

// File: tb/period_timer_bench.sv
`timescale 1ns/1ps
module period_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       matchPulse;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  period_timer u_period_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .matchPulse(matchPulse), .irq(irq)
  );

  // vector: ctrl, period, ticks, expected count, expected flag
  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  period;
    logic [15:0] ticks;
    logic [7:0]  expCount;
    logic        expFlag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 8'd5, 16'd4,  8'd4, 1'b0},  // R3 1:1
    '{8'h04, 8'd5, 16'd6,  8'd0, 1'b1},  // R3 R5 wrap
    '{8'h05, 8'd3, 16'd12, 8'd3, 1'b0},  // R2 1:4
    '{8'h05, 8'd3, 16'd16, 8'd0, 1'b1},  // R2 1:4 wrap
    '{8'h06, 8'd2, 16'd48, 8'd0, 1'b1},  // R2 code 10 -> 1:16
    '{8'h07, 8'd2, 16'd32, 8'd2, 1'b0},  // R2 code 11 -> 1:16
    '{8'h14, 8'd1, 16'd5,  8'd1, 1'b0},  // R5 post 1:3, two matches
    '{8'h14, 8'd1, 16'd6,  8'd0, 1'b1},  // R5 third match
    '{8'h7C, 8'd0, 16'd15, 8'd0, 1'b0},  // R10 R5 post 1:16, 15 matches
    '{8'h7C, 8'd0, 16'd16, 8'd0, 1'b1},  // R10 R5 sixteenth match
    '{8'h00, 8'd5, 16'd10, 8'd0, 1'b0}   // R9 disabled
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [7:0] per, input logic [7:0] cnt);
    wr(2'd2, 8'h00);
    wr(2'd1, per);
    wr(2'd0, cnt);
    wr(2'd3, 8'h00);
    wr(2'd2, ctrl);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd1, v); check("R1 period", v, 8'hFF);
    rd(2'd2, v); check("R1 ctrl", v, 8'h00);
    rd(2'd3, v); check("R1 intr", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // vector table
    for (int k = 0; k < NV; k++) begin
      setup(VECS[k].ctrl, VECS[k].period, 8'h00);
      ticks(int'(VECS[k].ticks));
      rd(2'd0, v); check($sformatf("R3 vec%0d count", k), v, VECS[k].expCount);
      rd(2'd3, v); check($sformatf("R5 vec%0d flag", k), {7'd0, v[0]}, {7'd0, VECS[k].expFlag});
    end

    // R2 bit 7 reads zero
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R2 bit7", v, 8'h7F);

    // R4 match pulse is one cycle, with count at period
    setup(8'h04, 8'd2, 8'd2);
    @(negedge clk); tickEn = 1'b1;
    #1 check("R4 pulse high", {7'd0, matchPulse}, 8'd1);
    @(negedge clk); tickEn = 1'b0;
    #1 check("R4 pulse low", {7'd0, matchPulse}, 8'd0);
    rd(2'd0, v); check("R4 wrapped", v, 8'd0);

    // R6 sticky flag and irq gating
    rd(2'd3, v); check("R6 flag set", {7'd0, v[0]}, 8'd1);
    check("R6 irq off", {7'd0, irq}, 8'd0);
    ticks(3);
    rd(2'd3, v); check("R6 still set", {7'd0, v[0]}, 8'd1);
    wr(2'd3, 8'h03);
    #1 check("R6 irq on", {7'd0, irq}, 8'd1);
    wr(2'd3, 8'h02);
    #1 check("R6 irq clr", {7'd0, irq}, 8'd0);
    rd(2'd3, v); check("R6 cleared", v, 8'h02);

    // R7 control write keeps count, restarts prescaler
    setup(8'h05, 8'd50, 8'd3);
    ticks(3);
    wr(2'd2, 8'h05);
    rd(2'd0, v); check("R7 count kept", v, 8'd3);
    ticks(3);
    rd(2'd0, v); check("R7 prescaler restart", v, 8'd3);
    ticks(1);
    rd(2'd0, v); check("R7 step after 4", v, 8'd4);

    // R8 count write loads and restarts prescaler
    ticks(3);
    wr(2'd0, 8'd7);
    rd(2'd0, v); check("R8 load", v, 8'd7);
    ticks(3);
    rd(2'd0, v); check("R8 prescaler restart", v, 8'd7);
    ticks(1);
    rd(2'd0, v); check("R8 step", v, 8'd8);

    // R9 disabled holds, writes still apply
    wr(2'd2, 8'h01);
    ticks(10);
    rd(2'd0, v); check("R9 hold", v, 8'd8);
    wr(2'd1, 8'd9);
    rd(2'd1, v); check("R9 period write", v, 8'd9);
    wr(2'd0, 8'd9);
    rd(2'd0, v); check("R9 count write", v, 8'd9);
    wr(2'd2, 8'h04);
    ticks(1);
    rd(2'd0, v); check("R9 resume wrap", v, 8'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule